// File: doc/BRIEF.md
# Indirect Calibration Register Port

This block gives a bus master access to a hidden bank of 64 words of 32 bits each. The bank has no address of its own on the register bus. The master reaches it through four bus registers, each selected by a 2-bit word index:

| Index | Register | Access |
|-------|----------|--------|
| 0 | command | read/write |
| 1 | outgoing data | read/write |
| 2 | incoming data | read-only |
| 3 | trigger | read/write |

To make an access, the master first sets the hidden address and the direction in the command register. For a write it also loads the outgoing data register. It then raises the trigger bit and lowers it again. The block carries out exactly one read or one write into the bank for each rising trigger.

The bank is write-protected. Entry 0 can always be written. Every other entry accepts a write only while entry 0 holds the unlock code.

The analog circuit that would sit behind the bank is not modelled. The bank here is plain storage.

Top module: `cal_port`

## Requirements
- R1: After reset, all four bus registers read zero and every hidden entry reads zero.
- R2: The command register keeps the hidden address in bits [5:0] and the direction in bit 8, where 1 means read and 0 means write. Every other bit reads back as zero.
- R3: A hidden access starts only when bit 0 of the trigger register (index 3) is written as 1 while it holds 0. Writing 1 again while it already holds 1 starts nothing.
- R4: A hidden write stores the value that the outgoing data register (index 1) held when the trigger rose. Changes made to that register later have no effect on the stored value.
- R5: A hidden read copies the addressed entry into the incoming data register (index 2). The outgoing data register is left unchanged. A bus read of index 2 issued two cycles after the trigger write returns the new value.
- R6: The incoming data register keeps its value until the next hidden read completes. Hidden writes do not change it.
- R7: A hidden write to entry 0 always takes effect. A hidden write to any other entry takes effect only while entry 0 equals UNLOCK_CODE (default 32'hA500_0000); otherwise it is dropped. Hidden reads are never blocked.
- R8: The bus returns read data with `bus_rvalid_o` high exactly one cycle after each read request. A bus write to index 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus request, one cycle per transfer |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register word index |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, registered |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the request |

## Verification
Several internal faults would show up at the ports within a few bus transfers:

- **Repeated trigger.** If a held trigger started a second access, a later value would overwrite the first. This shows on the next hidden read.
- **Stale operand capture.** If the block sampled the outgoing data too late, the wrong word would be stored. This also shows on the next hidden read.
- **Broken write protection.** A dropped unlock check either lets a locked entry change or blocks an unlocked one. Reading that entry back right after the write exposes it.
- **Corrupted incoming data.** If a hidden write disturbed the incoming data register, a direct bus read of index 2 would show the change at once.

// File: rtl/cal_port_pkg.sv
package cal_port_pkg;
  localparam int unsigned HID_AW  = 6;
  localparam int unsigned DW      = 32;
  localparam int unsigned BUS_AW  = 2;
  localparam int unsigned DIR_BIT = 8;
  localparam logic [DW-1:0] UNLOCK_DEFAULT = 32'hA500_0000;

  typedef enum logic [BUS_AW-1:0] {
    REG_CMD   = 2'd0,
    REG_WDATA = 2'd1,
    REG_RDATA = 2'd2,
    REG_TRIG  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cal_port_csr.sv
module cal_port_csr
  import cal_port_pkg::*;
#(
  parameter int unsigned AW      = HID_AW,
  parameter int unsigned W       = DW,
  parameter int unsigned DIR_POS = DIR_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [W-1:0]      rd_q_i,
  output logic [AW-1:0]     cmd_addr_o,
  output logic              cmd_rd_o,
  output logic [W-1:0]      wdata_o,
  output logic              trig_q_o,
  output logic              trig_rise_o
);
  logic [AW-1:0] cmd_addr_q;
  logic          cmd_rd_q;
  logic [W-1:0]  wdata_q;
  logic          trig_q;
  logic          wr_en, rd_en;
  logic [W-1:0]  cmd_word, rd_mux;

  assign wr_en = bus_valid_i && bus_write_i;
  assign rd_en = bus_valid_i && !bus_write_i;

  // start only on 0 -> 1 of the stored trigger bit
  assign trig_rise_o = wr_en && (bus_addr_i == REG_TRIG) && bus_wdata_i[0] && !trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_addr_q <= '0;
      cmd_rd_q   <= 1'b0;
      wdata_q    <= '0;
      trig_q     <= 1'b0;
    end else if (wr_en) begin
      unique case (bus_addr_i)
        REG_CMD: begin
          cmd_addr_q <= bus_wdata_i[AW-1:0];
          cmd_rd_q   <= bus_wdata_i[DIR_POS];
        end
        REG_WDATA: wdata_q <= bus_wdata_i;
        REG_TRIG:  trig_q  <= bus_wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd_word          = '0;
    cmd_word[AW-1:0]  = cmd_addr_q;
    cmd_word[DIR_POS] = cmd_rd_q;
  end

  always_comb begin
    unique case (bus_addr_i)
      REG_CMD:   rd_mux = cmd_word;
      REG_WDATA: rd_mux = wdata_q;
      REG_RDATA: rd_mux = rd_q_i;
      default:   rd_mux = {{(W-1){1'b0}}, trig_q};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      bus_rvalid_o <= rd_en;
      if (rd_en) bus_rdata_o <= rd_mux;
    end
  end

  assign cmd_addr_o = cmd_addr_q;
  assign cmd_rd_o   = cmd_rd_q;
  assign wdata_o    = wdata_q;
  assign trig_q_o   = trig_q;
endmodule

// File: rtl/cal_port_seq.sv
module cal_port_seq
  import cal_port_pkg::*;
#(
  parameter int unsigned AW = HID_AW,
  parameter int unsigned W  = DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_rise_i,
  input  logic          cmd_rd_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  rd_word_i,
  output logic          acc_go_o,
  output logic          acc_rd_o,
  output logic [AW-1:0] acc_addr_o,
  output logic [W-1:0]  acc_data_o,
  output logic [W-1:0]  rd_q_o
);
  logic          go_q, rd_dir_q;
  logic [AW-1:0] addr_q;
  logic [W-1:0]  data_q, rd_q;

  // operands frozen at the trigger edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q     <= 1'b0;
      rd_dir_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      go_q <= trig_rise_i;
      if (trig_rise_i) begin
        rd_dir_q <= cmd_rd_i;
        addr_q   <= cmd_addr_i;
        data_q   <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rd_q <= '0;
    else if (go_q && rd_dir_q) rd_q <= rd_word_i;
  end

  assign acc_go_o   = go_q;
  assign acc_rd_o   = rd_dir_q;
  assign acc_addr_o = addr_q;
  assign acc_data_o = data_q;
  assign rd_q_o     = rd_q;
endmodule

// File: rtl/cal_port_bank.sv
module cal_port_bank
  import cal_port_pkg::*;
#(
  parameter int unsigned   AW     = HID_AW,
  parameter int unsigned   W      = DW,
  parameter logic [W-1:0]  UNLOCK = UNLOCK_DEFAULT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_go_i,
  input  logic          acc_rd_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [W-1:0]  acc_data_i,
  output logic [W-1:0]  rd_word_o,
  output logic          commit_o,
  output logic [W-1:0]  ent0_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic         open;
  logic         wr_req;

  assign open   = (mem[0] == UNLOCK);
  assign wr_req = acc_go_i && !acc_rd_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic we;
    if (g == 0) begin : g_key
      assign we = wr_req && (acc_addr_i == AW'(g));
    end else begin : g_prot
      assign we = wr_req && open && (acc_addr_i == AW'(g));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem[g] <= '0;
      else if (we)  mem[g] <= acc_data_i;
    end
  end

  assign rd_word_o = mem[acc_addr_i];
  assign commit_o  = wr_req && ((acc_addr_i == '0) || open);
  assign ent0_o    = mem[0];
endmodule

// File: rtl/cal_port.sv
module cal_port
  import cal_port_pkg::*;
#(
  parameter int unsigned  AW          = HID_AW,
  parameter int unsigned  W           = DW,
  parameter int unsigned  DIR_POS     = DIR_BIT,
  parameter logic [W-1:0] UNLOCK_CODE = UNLOCK_DEFAULT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  output logic              bus_rvalid_o
);
  logic [AW-1:0] cmd_addr, acc_addr;
  logic          cmd_rd, trig_q, trig_rise;
  logic          acc_go, acc_rd, commit;
  logic [W-1:0]  wdata, acc_data, rd_word, rd_q, ent0;

  cal_port_csr #(.AW(AW), .W(W), .DIR_POS(DIR_POS)) u_csr (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .bus_rvalid_o,
    .rd_q_i      (rd_q),
    .cmd_addr_o  (cmd_addr),
    .cmd_rd_o    (cmd_rd),
    .wdata_o     (wdata),
    .trig_q_o    (trig_q),
    .trig_rise_o (trig_rise)
  );

  cal_port_seq #(.AW(AW), .W(W)) u_seq (
    .clk_i, .rst_ni,
    .trig_rise_i (trig_rise),
    .cmd_rd_i    (cmd_rd),
    .cmd_addr_i  (cmd_addr),
    .wdata_i     (wdata),
    .rd_word_i   (rd_word),
    .acc_go_o    (acc_go),
    .acc_rd_o    (acc_rd),
    .acc_addr_o  (acc_addr),
    .acc_data_o  (acc_data),
    .rd_q_o      (rd_q)
  );

  cal_port_bank #(.AW(AW), .W(W), .UNLOCK(UNLOCK_CODE)) u_bank (
    .clk_i, .rst_ni,
    .acc_go_i   (acc_go),
    .acc_rd_i   (acc_rd),
    .acc_addr_i (acc_addr),
    .acc_data_i (acc_data),
    .rd_word_o  (rd_word),
    .commit_o   (commit),
    .ent0_o     (ent0)
  );
endmodule

// File: rtl/cal_port_chk.sv
module cal_port_chk
  import cal_port_pkg::*;
#(
  parameter int unsigned  AW     = HID_AW,
  parameter int unsigned  W      = DW,
  parameter logic [W-1:0] UNLOCK = UNLOCK_DEFAULT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic [W-1:0]      bus_wdata_i,
  input logic              bus_rvalid_o,
  input logic              trig_q,
  input logic              acc_go,
  input logic              acc_rd,
  input logic [AW-1:0]     acc_addr,
  input logic [W-1:0]      rd_q,
  input logic              commit,
  input logic [W-1:0]      ent0
);
  logic trig_wr1;
  assign trig_wr1 = bus_valid_i && bus_write_i && (bus_addr_i == REG_TRIG) && bus_wdata_i[0];

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o); // R8
  AST_RVALID_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> $past(bus_valid_i && !bus_write_i)); // R8
  AST_GO_NEEDS_TRIGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_go |-> $past(trig_wr1)); // R3
  AST_GO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_go |=> !acc_go); // R3
  AST_HELD_TRIGGER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_wr1 && trig_q) |=> !acc_go); // R3
  AST_RDATA_KEPT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_go && !acc_rd) |=> $stable(rd_q)); // R6
  AST_LOCKED_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && (acc_addr != '0)) |-> (ent0 == UNLOCK)); // R7
endmodule

bind cal_port cal_port_chk #(.AW(AW), .W(W), .UNLOCK(UNLOCK_CODE)) u_chk (
  .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i,
  .bus_rvalid_o, .trig_q, .acc_go, .acc_rd, .acc_addr, .rd_q, .commit, .ent0
);

// File: tb/cal_port_test.sv
`timescale 1ns/1ps
module cal_port_test;
  localparam logic [31:0] UNL = 32'hA500_0000;
  localparam logic [1:0]  A_CMD = 2'd0, A_WD = 2'd1, A_RD = 2'd2, A_TRIG = 2'd3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic        bus_write_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        bus_rvalid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] mem_m [64];
  logic [31:0] exp_rd = '0;
  logic [31:0] got;

  always #2.5 clk_i = ~clk_i;

  cal_port uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i); #1;
    bus_valid_i = 1'b0; bus_write_i = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = a;
    @(posedge clk_i); #1;
    bus_valid_i = 1'b0;
    @(negedge clk_i);
    checks++;
    if (!bus_rvalid_o) begin
      errors++;
      $display("FAIL R8: rvalid actual 0 expected 1");
    end
    d = bus_rdata_o;
  endtask

  function automatic bit model_wr_ok(input int a);
    return (a == 0) || (mem_m[0] == UNL);
  endfunction

  task automatic hid_write(input int a, input logic [31:0] d);
    bw(A_CMD, 32'(a));
    bw(A_WD, d);
    bw(A_TRIG, 32'd1);
    bw(A_TRIG, 32'd0);
    if (model_wr_ok(a)) mem_m[a] = d;
  endtask

  task automatic hid_read(input int a, input string tag);
    bw(A_CMD, 32'h100 | 32'(a));
    bw(A_TRIG, 32'd1);
    bw(A_TRIG, 32'd0);
    exp_rd = mem_m[a];
    br(A_RD, got);
    check(tag, got, exp_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] wd_before;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    br(A_CMD, got);  check("R1 cmd", got, 0);
    br(A_WD, got);   check("R1 wdata", got, 0);
    br(A_RD, got);   check("R1 rdata", got, 0);
    br(A_TRIG, got); check("R1 trig", got, 0);
    hid_read(0, "R1 entry0");
    hid_read(63, "R1 entry63");

    // R2 reserved bits of command register
    bw(A_CMD, 32'hFFFF_FFFF); br(A_CMD, got); check("R2 cmd mask", got, 32'h13F);
    bw(A_CMD, 32'h0000_00AA); br(A_CMD, got); check("R2 cmd write dir", got, 32'h2A);

    // R7 locked write dropped
    hid_write(9, 32'hDEAD_BEEF);
    hid_read(9, "R7 locked");
    hid_write(0, UNL);
    hid_read(0, "R7 key stored");
    hid_write(9, 32'h1234_5678);
    hid_read(9, "R7 unlocked");
    hid_write(0, 32'h0000_0001);
    hid_write(9, 32'h5555_AAAA);
    hid_read(9, "R7 relocked");
    hid_write(0, UNL);

    // R3/R4 held trigger does not repeat; operand frozen at edge
    bw(A_CMD, 32'd5);
    bw(A_WD, 32'hAAAA_0001);
    bw(A_TRIG, 32'd1);
    bw(A_WD, 32'hBBBB_0002);
    bw(A_TRIG, 32'd1);
    bw(A_TRIG, 32'd0);
    mem_m[5] = 32'hAAAA_0001;
    hid_read(5, "R3 R4 held trigger");

    // R5 read leaves outgoing data register alone
    bw(A_WD, 32'hCAFE_F00D);
    hid_read(9, "R5 read value");
    br(A_WD, got); check("R5 wdata kept", got, 32'hCAFE_F00D);

    // R6 incoming data survives a write access
    hid_write(12, 32'h0BAD_CAFE);
    br(A_RD, got); check("R6 hold after write", got, exp_rd);

    // R8 bus write to read-only register ignored
    bw(A_RD, 32'hFFFF_FFFF);
    br(A_RD, got); check("R8 rdata read-only", got, exp_rd);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int unsigned sel = $urandom % 8;
      int a = int'($urandom % 64);
      logic [31:0] d = $urandom;
      case (sel)
        0: hid_write(0, ($urandom % 3 != 0) ? UNL : d);
        1, 2, 3: hid_write(a, d);
        4, 5, 6: hid_read(a, "R5 R7 random read");
        default: begin
          br(A_RD, got); check("R6 random hold", got, exp_rd);
        end
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule